// File: doc/BRIEF.md
# Write-Only Two-Wire Byte Streamer

This block copies a stream of pixel bytes onto a pair of open-drain lines, a clock line and a data line, using an I2C-like bit framing. It only ever transmits. Each output port reads 1 when the line is released and 0 when it is pulled low. A one-cycle `start_i` pulse in idle begins a frame. The block opens the frame with a start condition and sends the fixed header byte 0x84. It then takes four payload bytes per pixel from a valid/ready byte port and ends with a stop condition. The block does not sample an acknowledge, does not read, and does not arbitrate.

All line timing is built from a unit delay. The unit delay is a count of system clocks derived from the clock frequency and a unit time in nanoseconds. The defaults give 1 µs at 50 MHz. The bit cell takes three units. In the first, data carries the bit and the clock is released. In the second, the clock is low. In the third, data is pulled low. Every byte carries a ninth bit that is always 0, and two idle units follow it.

Top module: `twowire_streamer`

## Requirements
- R1: After reset and whenever `busy_o` is 0, `line_clk_o` and `line_dat_o` are both 1 (released) and `byte_ready_o` is 0.
- R2: A frame opens with both lines released for two units, counted from the first cycle `busy_o` is high plus one cycle. Data then falls while the clock stays released, and the clock falls one unit after that.
- R3: Bits leave most significant bit first. The clock is released for exactly one unit per bit, data does not change while the clock is released inside a byte, and consecutive clock pulses within a byte are separated by two units of clock low.
- R4: The ninth clock pulse of every byte carries data 0.
- R5: One unit after each clock falls, data is pulled low, whatever the value of the bit.
- R6: The first byte after the start condition is 0x84.
- R7: Exactly 4×N payload bytes follow the header, where N is `pixel_count_i` captured with the accepted start pulse. Later changes of `pixel_count_i` have no effect, and N = 0 gives a header-only frame.
- R8: `byte_ready_o` is high only while the block waits for a payload byte. Bytes are taken in order on `byte_valid_i && byte_ready_o`. While it waits, both lines are held low for as long as needed.
- R9: A frame ends by releasing the clock and then, one unit later, releasing data. `busy_o` drops after that.
- R10: A `start_i` pulse while `busy_o` is high is ignored and produces no second start condition.
- R11: From the ninth clock falling edge to the next clock rising edge there are four units. When a payload byte follows, one extra cycle is added if valid is already high; when the stop condition follows, nothing is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle frame request, taken only in idle |
| pixel_count_i | input | PIX_W | Pixel count N, captured at start |
| byte_data_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte is valid |
| byte_ready_o | output | 1 | Block is waiting for a payload byte |
| busy_o | output | 1 | Frame in progress |
| line_clk_o | output | 1 | Clock line, 1 = released, 0 = pulled low |
| line_dat_o | output | 1 | Data line, 1 = released, 0 = pulled low |

## Verification
A sequencer stuck in a wrong state or off by one in its unit count shows up at the ports within one bit cell. The clock-high width stops being exactly one unit, or the low gap stops being two units. A slip in the bit index moves the forced-low ninth bit into the data and corrupts the decoded byte at the next clock pulse. A byte counter that was not latched, or that counts wrong, shows up as a wrong number of bytes when the stop condition appears. A wrong line decode shows up as a spurious start or stop edge while the clock is high.

// File: rtl/twl_pkg.sv
package twl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_INIT, ST_REL, ST_DLO, ST_CLO, ST_LOAD,
    ST_BHI, ST_BLO, ST_BEND, ST_GAP, ST_PCLK, ST_PDAT
  } twl_state_e;

  localparam logic [7:0] HEAD_BYTE = 8'h84;
  localparam int unsigned GAP_UNITS = 2;
  localparam int unsigned BITS_PER_BYTE = 9;
endpackage

// File: rtl/twl_unit_timer.sv
module twl_unit_timer #(
  parameter int unsigned UNIT_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/twl_bit_shifter.sv
module twl_bit_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  input  logic       shift_i,
  output logic       bit_o,
  output logic       last_o
);
  import twl_pkg::*;

  logic [7:0] sh_q;
  logic [3:0] idx_q;

  // ninth slot is forced low
  assign bit_o  = (idx_q < 4'd8) ? sh_q[7] : 1'b0;
  assign last_o = (idx_q == 4'(BITS_PER_BYTE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[6:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/twl_line_drive.sv
module twl_line_drive (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  twl_pkg::twl_state_e state_i,
  input  logic                bit_i,
  output logic                line_clk_o,
  output logic                line_dat_o
);
  import twl_pkg::*;

  logic clk_d, dat_d;

  always_comb begin
    clk_d = 1'b0;
    dat_d = 1'b0;
    unique case (state_i)
      ST_IDLE, ST_INIT, ST_REL, ST_PDAT: begin clk_d = 1'b1; dat_d = 1'b1; end
      ST_DLO, ST_PCLK:                   begin clk_d = 1'b1; dat_d = 1'b0; end
      ST_BHI:                            begin clk_d = 1'b1; dat_d = bit_i; end
      ST_BLO:                            begin clk_d = 1'b0; dat_d = bit_i; end
      ST_CLO, ST_LOAD, ST_BEND, ST_GAP:  begin clk_d = 1'b0; dat_d = 1'b0; end
      default:                           begin clk_d = 1'b1; dat_d = 1'b1; end
    endcase
  end

  // registered pad drive, released in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_clk_o <= 1'b1;
      line_dat_o <= 1'b1;
    end else begin
      line_clk_o <= clk_d;
      line_dat_o <= dat_d;
    end
  end
endmodule

// File: rtl/twl_frame_ctrl.sv
module twl_frame_ctrl #(
  parameter int unsigned PIX_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [PIX_W-1:0]    pixel_count_i,
  input  logic [7:0]          byte_data_i,
  input  logic                byte_valid_i,
  input  logic                tick_i,
  input  logic                last_i,
  output logic                run_o,
  output logic                load_o,
  output logic [7:0]          load_byte_o,
  output logic                shift_o,
  output logic                ready_o,
  output logic                busy_o,
  output twl_pkg::twl_state_e state_o
);
  import twl_pkg::*;

  localparam int unsigned RW = PIX_W + 2;
  localparam int unsigned GW = (GAP_UNITS > 1) ? $clog2(GAP_UNITS) : 1;

  twl_state_e     st_q, st_d;
  logic [RW-1:0]  rem_q, rem_d;
  logic [GW-1:0]  gap_q, gap_d;

  always_comb begin
    st_d        = st_q;
    rem_d       = rem_q;
    gap_d       = gap_q;
    load_o      = 1'b0;
    load_byte_o = HEAD_BYTE;
    shift_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_INIT;
        rem_d = {pixel_count_i, 2'b00};  // four bytes per pixel
      end
      ST_INIT: if (tick_i) st_d = ST_REL;
      ST_REL:  if (tick_i) st_d = ST_DLO;
      ST_DLO:  if (tick_i) st_d = ST_CLO;
      ST_CLO:  if (tick_i) begin
        st_d   = ST_BHI;
        load_o = 1'b1;
      end
      ST_LOAD: if (byte_valid_i) begin
        st_d        = ST_BHI;
        load_o      = 1'b1;
        load_byte_o = byte_data_i;
        rem_d       = rem_q - 1'b1;
      end
      ST_BHI:  if (tick_i) st_d = ST_BLO;
      ST_BLO:  if (tick_i) st_d = ST_BEND;
      ST_BEND: if (tick_i) begin
        gap_d = '0;
        if (last_i) st_d = ST_GAP;
        else begin
          st_d    = ST_BHI;
          shift_o = 1'b1;
        end
      end
      ST_GAP:  if (tick_i) begin
        if (gap_q == GW'(GAP_UNITS - 1)) st_d = (rem_q != '0) ? ST_LOAD : ST_PCLK;
        else gap_d = gap_q + 1'b1;
      end
      ST_PCLK: if (tick_i) st_d = ST_PDAT;
      ST_PDAT: if (tick_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      gap_q <= gap_d;
    end
  end

  assign run_o   = (st_q != ST_IDLE) && (st_q != ST_LOAD);
  assign ready_o = (st_q == ST_LOAD);
  assign busy_o  = (st_q != ST_IDLE);
  assign state_o = st_q;
endmodule

// File: rtl/twowire_streamer.sv
module twowire_streamer #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned UNIT_NS = 1000,
  parameter int unsigned PIX_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PIX_W-1:0] pixel_count_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             busy_o,
  output logic             line_clk_o,
  output logic             line_dat_o
);
  import twl_pkg::*;

  localparam int unsigned UNIT_RAW = ((CLK_HZ / 1000) * UNIT_NS) / 1_000_000;
  localparam int unsigned UNIT_CYC = (UNIT_RAW < 1) ? 1 : UNIT_RAW;

  logic       run, tick, load, shift, cur_bit, last_bit;
  logic [7:0] load_byte;
  twl_state_e state;

  twl_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .tick_o(tick)
  );

  twl_frame_ctrl #(.PIX_W(PIX_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .pixel_count_i, .byte_data_i, .byte_valid_i,
    .tick_i(tick), .last_i(last_bit), .run_o(run), .load_o(load),
    .load_byte_o(load_byte), .shift_o(shift), .ready_o(byte_ready_o),
    .busy_o, .state_o(state)
  );

  twl_bit_shifter u_shift (
    .clk_i, .rst_ni, .load_i(load), .byte_i(load_byte), .shift_i(shift),
    .bit_o(cur_bit), .last_o(last_bit)
  );

  twl_line_drive u_drive (
    .clk_i, .rst_ni, .state_i(state), .bit_i(cur_bit),
    .line_clk_o, .line_dat_o
  );
endmodule

// File: rtl/twowire_streamer_chk.sv
module twowire_streamer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic byte_valid_i,
  input logic byte_ready_o,
  input logic busy_o,
  input logic line_clk_o,
  input logic line_dat_o
);
  // R1
  idle_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (line_clk_o && line_dat_o && !byte_ready_o));

  // R8
  wait_lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!line_clk_o && !line_dat_o && busy_o));

  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_ready_o && !byte_valid_i) |=> byte_ready_o);

  // R2
  frame_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (line_clk_o && line_dat_o));

  // R9
  frame_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (line_clk_o && line_dat_o && $past(line_clk_o)));
endmodule

bind twowire_streamer twowire_streamer_chk u_chk (.*);

// File: tb/twowire_streamer_tb.sv
module twowire_streamer_tb;
  localparam int U = 4;  // 80 ns at 50 MHz
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] pix = '0;
  logic [7:0] bdata;
  logic bvalid, bready, busy, lclk, ldat;

  always #10 clk = ~clk;

  twowire_streamer #(.CLK_HZ(50_000_000), .UNIT_NS(80), .PIX_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pixel_count_i(pix),
    .byte_data_i(bdata), .byte_valid_i(bvalid), .byte_ready_o(bready),
    .busy_o(busy), .line_clk_o(lclk), .line_dat_o(ldat)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // byte source
  logic [7:0] src_mem [0:63];
  int src_len = 0, src_idx = 0, rdy_cnt = 0;
  bit src_clr = 0, stall = 0;
  assign bdata  = src_mem[src_idx[5:0]];
  assign bvalid = (src_idx < src_len) && (!stall || rdy_cnt >= 9);

  always @(posedge clk) begin
    if (src_clr) src_idx <= 0;
    else if (bvalid && bready) src_idx <= src_idx + 1;
    rdy_cnt <= bready ? rdy_cnt + 1 : 0;
  end

  // line monitor
  int cyc = 0, busy_rise = 0, rise_c = 0, fall_c = 0, end_chk = -1;
  int bitcnt = 0, nbytes = 0, starts = 0, stops = 0, gap_iv = 0;
  bit prev_c = 1, prev_d = 1, prev_b = 0, in_frame = 0, gap_pend = 0;
  logic [7:0] shreg = '0;
  logic [7:0] rec [0:63];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !prev_b) busy_rise = cyc;
      if (bready) check(!lclk && !ldat, "R8 lines low while waiting", {lclk, ldat}, 0);
      if (lclk && prev_c && prev_d && !ldat) begin
        starts++;
        check(cyc - busy_rise == 2*U + 1, "R2 start data fall", cyc - busy_rise, 2*U + 1);
        in_frame = 1; bitcnt = 0; nbytes = 0; fall_c = cyc;
      end else if (lclk && prev_c && !prev_d && ldat) begin
        stops++;
        check(cyc - rise_c == U, "R9 stop data release", cyc - rise_c, U);
        if (gap_pend) check(gap_iv == 4*U, "R11 gap before stop", gap_iv, 4*U);
        gap_pend = 0; in_frame = 0;
      end else if (lclk && !prev_c && in_frame) begin
        if (bitcnt > 0 && bitcnt % 9 == 0) begin
          gap_iv = cyc - fall_c; gap_pend = 1;
        end else if (bitcnt % 9 != 0)
          check(cyc - fall_c == 2*U, "R3 low gap in byte", cyc - fall_c, 2*U);
        rise_c = cyc;
        if (bitcnt % 9 == 8) check(ldat == 1'b0, "R4 ninth bit", ldat, 0);
        else begin
          shreg = {shreg[6:0], ldat};
          if (bitcnt % 9 == 7) begin
            if (nbytes < 64) rec[nbytes] = shreg;
            nbytes++;
          end
        end
        bitcnt++;
      end else if (!lclk && prev_c && in_frame) begin
        if (bitcnt == 0)
          check(cyc - fall_c == U, "R2 clock fall after data", cyc - fall_c, U);
        else begin
          check(cyc - rise_c == U, "R3 clock high width", cyc - rise_c, U);
          end_chk = cyc + U + 1;
          if (gap_pend && !stall)
            check(gap_iv == 4*U + 1, "R11 gap between bytes", gap_iv, 4*U + 1);
          gap_pend = 0;
        end
        fall_c = cyc;
      end
      if (cyc == end_chk && in_frame) check(ldat == 1'b0, "R5 data low after bit", ldat, 0);
    end
    prev_c = lclk; prev_d = ldat; prev_b = busy;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(lclk && ldat, "R1 lines released in reset", {lclk, ldat}, 3);
    check(!busy && !bready, "R1 idle flags", {busy, bready}, 0);
  endtask

  task automatic t_frame(input int n, input bit stall_m, input bit disturb, input int seed);
    int s0, waited;
    bit done;
    for (int i = 0; i < 64; i++) src_mem[i] = 8'((i * 37 + seed * 11) ^ 8'h5a);
    src_len = 4 * n; stall = stall_m;
    @(negedge clk); src_clr = 1;
    @(negedge clk); src_clr = 0;
    pix = PW'(n); s0 = starts;
    pulse_start();
    check(busy, "R2 busy after start", busy, 1);
    waited = 0; done = 0;
    while (!done && waited < 20000) begin
      @(negedge clk); waited++;
      if (disturb && waited == 150) begin
        pix = PW'(n + 3); start = 1'b1;
      end else start = 1'b0;
      if (!busy) done = 1;
    end
    check(done, "watchdog frame end", waited, 0);
    check(starts - s0 == 1, "R10 single start", starts - s0, 1);
    check(!in_frame, "R9 stop seen", in_frame, 0);
    check(nbytes == 1 + 4*n, "R7 byte count", nbytes, 1 + 4*n);
    check(rec[0] == 8'h84, "R6 header byte", rec[0], 8'h84);
    for (int i = 1; i < nbytes && i < 64; i++)
      check(rec[i] == src_mem[i-1], "R3 payload msb first", rec[i], src_mem[i-1]);
    check(src_idx == 4*n, "R8 bytes consumed", src_idx, 4*n);
    @(negedge clk);
    check(lclk && ldat && !bready, "R1 idle after frame", {lclk, ldat, bready}, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_frame(2, 0, 0, 1);   // R6 R7
    t_frame(0, 0, 0, 2);   // R7 header only
    t_frame(3, 1, 0, 3);   // R8 stall
    t_frame(1, 0, 1, 4);   // R7 R10 mid-frame changes
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule